// File: doc/BRIEF.md
# Board interrupt level encoder with control registers

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and gives a processor one 4-bit interrupt level code. Each request line has three fixed attributes: a priority level from 0 to 12, a bit position in a 16-bit monitor word and the same bit position in a 16-bit mask word. A request counts only when both its monitor bit and its mask bit are set. The most urgent pending request is the one with the lowest level number. That level is inverted before it leaves the block, so an idle board drives code 0.

Software reaches the block through a 16-bit register port with a 64-byte address window. The window holds a read/write mask register, a read/write general output port, a fixed version register and a power-off control. Writing the power-off control with bit 0 set gives a single-cycle pulse on `pwr_off`.

Top module: `irq_level_ctrl`

## Requirements
- R1: `irq_in[i]` is the request of the source with priority level i. Its monitor bit follows the input level, and `irl_code` reflects an input change one clock after the edge that samples it.
- R2: A source contributes only when its mask bit and its monitor bit are both 1. The fixed level-to-bit mapping is: level 0 bit 11, level 1 bit 9, level 2 bit 8, level 3 bit 12, level 4 bit 10, level 5 bit 6, level 6 bit 5, level 7 bit 4, level 8 bit 7, level 9 bit 14, level 10 bit 13, level 11 bit 0, level 12 bit 15.
- R3: Among contributing sources the lowest level number L wins, and `irl_code` = L XOR 15.
- R4: With no contributing source, `irl_code` is 0 (internal level 15).
- R5: The mask register sits at byte offset 0x00. It reads back what was last written, and a write changes `irl_code` from the next clock.
- R6: The output port register sits at offset 0x36. It reads back what was last written and drives `out_port` from the clock after the write.
- R7: The version register at offset 0x32 always reads 0x0010, and writes to it change no state.
- R8: The power-off control at offset 0x30 reads 0. A write with bit 0 set makes `pwr_off` high for exactly the following cycle. A write with bit 0 clear leaves `pwr_off` low.
- R9: Accesses are 16-bit, so `addr[0]` is ignored. Any other offset in the window reads 0, and a write to such an offset changes nothing.
- R10: Reset (`rst_n` low) clears the mask, the output port and the monitor. After reset, `irl_code`, `pwr_off` and `out_port` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 13 | Request lines, index = priority level |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte offset in the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational from addr) |
| irl_code | output | 4 | Inverted winning level |
| out_port | output | 16 | General output port contents |
| pwr_off | output | 1 | Single-cycle power-off request |

## Verification
The hardest case to reach is a crowd of simultaneous requests in which some higher-priority sources are masked off and a lower-priority source must win. This exercises the scattered bit mapping and the priority order at the same time. The stimulus gets there by holding all thirteen lines high while walking single-bit masks, then by driving random request patterns under random masks. A behavioural model is compared against the block on every clock. Writes to the version and unmapped offsets, and odd addresses, are followed by read-backs to show they touch nothing.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter logic [15:0] VERSION = 16'h0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] irq_in,
  input  logic        sel,
  input  logic        wr,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic [3:0]  irl_code,
  output logic [15:0] out_port,
  output logic        pwr_off
);
  localparam int NSRC = 13;
  localparam logic [4:0] A_MASK = 5'h00;
  localparam logic [4:0] A_PWR  = 5'h18;
  localparam logic [4:0] A_VER  = 5'h19;
  localparam logic [4:0] A_PORT = 5'h1b;
  localparam logic [NSRC-1:0][3:0] BITPOS =
    {4'd15, 4'd0, 4'd13, 4'd14, 4'd7, 4'd4, 4'd5, 4'd6, 4'd10, 4'd12, 4'd8, 4'd9, 4'd11};

  logic [15:0] mask_q, mon_q, mon_d, port_q;
  logic [NSRC-1:0] elig;
  logic [3:0] win;
  wire [4:0] wa = addr[5:1];
  wire we = sel && wr;

  always_comb begin
    mon_d = '0;
    for (int i = 0; i < NSRC; i++) mon_d[BITPOS[i]] = irq_in[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q  <= '0;
      mon_q   <= '0;
      port_q  <= '0;
      pwr_off <= 1'b0;
    end else begin
      mon_q   <= mon_d;
      pwr_off <= we && wa == A_PWR && wdata[0];
      if (we && wa == A_MASK) mask_q <= wdata;
      if (we && wa == A_PORT) port_q <= wdata;
    end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_elig
      assign elig[g] = mon_q[BITPOS[g]] & mask_q[BITPOS[g]];
    end
  endgenerate

  always_comb begin
    win = 4'd15;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = 4'(i);
  end

  assign irl_code = win ^ 4'hf;
  assign out_port = port_q;

  always_comb
    case (wa)
      A_MASK:  rdata = mask_q;
      A_PORT:  rdata = port_q;
      A_VER:   rdata = VERSION;
      default: rdata = 16'h0000;
    endcase
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] irq_in,
  input logic        sel,
  input logic        wr,
  input logic [5:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [3:0]  irl_code,
  input logic        pwr_off,
  input logic [15:0] mask_q
);
  assert_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr[5:1] == 5'h19 |-> rdata == 16'h0010);
  assert_pwr_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr[5:1] == 5'h18 |-> rdata == 16'h0000);
  assert_pwr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> $past(sel && wr && addr[5:1] == 5'h18 && wdata[0]));
  assert_pwr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(sel && wr && addr[5:1] == 5'h18 && wdata[0]) |-> pwr_off);
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(irq_in) == 13'd0 |-> irl_code == 4'h0);
  assert_top_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(irq_in[0]) && mask_q[11] |-> irl_code == 4'hf);
  assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irl_code != 4'h1 && irl_code != 4'h2);
endmodule

bind irq_level_ctrl irq_level_ctrl_chk chk (.*);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [12:0] irq_in = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, out_port;
  logic [3:0] irl_code;
  logic pwr_off;
  int total = 0, bad = 0;
  bit done = 0;

  irq_level_ctrl uut (.*);

  always #10 clk = ~clk;

  logic [12:0] m_mon = '0;
  logic [15:0] m_mask = '0, m_port = '0;
  logic m_pwr = 1'b0;

  function automatic int bitpos(int lvl);
    case (lvl)
      0: return 11;  1: return 9;   2: return 8;   3: return 12;
      4: return 10;  5: return 6;   6: return 5;   7: return 4;
      8: return 7;   9: return 14;  10: return 13; 11: return 0;
      default: return 15;
    endcase
  endfunction

  function automatic logic [3:0] exp_code();
    for (int l = 0; l < 13; l++)
      if (m_mon[l] && m_mask[bitpos(l)]) return 4'(l ^ 15);
    return 4'h0;
  endfunction

  always @(posedge clk)
    if (!rst_n) begin
      m_mon <= '0; m_mask <= '0; m_port <= '0; m_pwr <= 1'b0;
    end else begin
      m_mon <= irq_in;
      m_pwr <= sel && wr && addr[5:1] == 5'h18 && wdata[0];
      if (sel && wr && addr[5:1] == 5'h00) m_mask <= wdata;
      if (sel && wr && addr[5:1] == 5'h1b) m_port <= wdata;
    end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check("R1/R2/R3/R4/R10 irl_code", {12'd0, irl_code}, {12'd0, exp_code()});
    check("R8/R10 pwr_off", {15'd0, pwr_off}, {15'd0, m_pwr});
    check("R6/R10 out_port", out_port, m_port);
  end

  task automatic wr_reg(logic [5:0] a, logic [15:0] d);
    @(negedge clk); #1;
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic rd_reg(string req, logic [5:0] a, logic [15:0] exp);
    @(negedge clk); #1;
    sel = 1; wr = 0; addr = a;
    #4 check(req, rdata, exp);
    @(negedge clk); #1;
    sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R10 reset irl_code", {12'd0, irl_code}, 16'd0);
    check("R10 reset out_port", out_port, 16'd0);
    @(negedge clk); #1 rst_n = 1;
    rd_reg("R10 mask after reset", 6'h00, 16'h0000);
    rd_reg("R7 version", 6'h32, 16'h0010);
    rd_reg("R8 power-off reads 0", 6'h30, 16'h0000);
    rd_reg("R9 unmapped 0x02", 6'h02, 16'h0000);

    irq_in = 13'h1fff; idle(2);
    check("R2 all masked", {12'd0, irl_code}, 16'd0);
    wr_reg(6'h00, 16'hffff);
    rd_reg("R5 mask readback", 6'h00, 16'hffff);
    check("R3 top level wins", {12'd0, irl_code}, 16'h000f);

    for (int l = 0; l < 13; l++) begin
      wr_reg(6'h00, 16'(1) << bitpos(l));
      idle(1);
      check("R2 single mask bit under full load", {12'd0, irl_code}, 16'(l ^ 15));
    end
    wr_reg(6'h00, 16'h000e);
    idle(1);
    check("R2 unused mask bits", {12'd0, irl_code}, 16'd0);

    wr_reg(6'h00, 16'hffff);
    for (int l = 0; l < 13; l++) begin
      @(negedge clk); #1 irq_in = 13'(1) << l;
      idle(2);
      check("R1 single source", {12'd0, irl_code}, 16'(l ^ 15));
    end
    @(negedge clk); #1 irq_in = 13'h1800;
    idle(2);
    check("R3 pair 11,12", {12'd0, irl_code}, 16'h0004);
    @(negedge clk); #1 irq_in = 13'h0;
    idle(2);
    check("R4 idle", {12'd0, irl_code}, 16'd0);

    wr_reg(6'h36, 16'hbeef);
    rd_reg("R6 port readback", 6'h36, 16'hbeef);
    rd_reg("R9 odd address alias", 6'h37, 16'hbeef);
    wr_reg(6'h32, 16'h1234);
    rd_reg("R7 version after write", 6'h32, 16'h0010);
    wr_reg(6'h3e, 16'h5555);
    rd_reg("R9 unmapped write", 6'h3e, 16'h0000);
    rd_reg("R9 mask untouched", 6'h00, 16'hffff);
    rd_reg("R9 port untouched", 6'h36, 16'hbeef);

    wr_reg(6'h30, 16'h0002);
    wr_reg(6'h30, 16'h0001);
    wr_reg(6'h31, 16'h0003);

    for (int k = 0; k < 600; k++) begin
      @(negedge clk); #1;
      irq_in = 13'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        sel = 1; wr = 1; addr = 6'h00; wdata = 16'($urandom);
      end else if ($urandom_range(0, 7) == 0) begin
        sel = 1; wr = 1; addr = 6'($urandom); wdata = 16'($urandom);
      end else begin
        sel = 0; wr = 0;
      end
    end
    @(negedge clk); #1 sel = 0; wr = 0;
    idle(3);
    @(negedge clk); #1 rst_n = 0;
    idle(2);
    check("R10 second reset irl_code", {12'd0, irl_code}, 16'd0);
    check("R10 second reset out_port", out_port, 16'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule